// File: doc/BRIEF.md
# Power Mode Event Interrupt Generator

This block sits next to the mode sequencer of a power management unit. Power modes form a fixed ladder: low-speed PLL, then Doze, Sleep, Suspend and Off. The block turns selected events into an interrupt for the processor. There are two kinds of event. The first is a request from the sequencer to step down one rung of the ladder. The second is a rising edge on one of three battery-low warnings or on the suspend/resume pin. Each event has its own bit in an 8-bit enable register. Every enable bit is clear after reset.

When the sequencer asks for an enabled step, the block withholds its go-ahead and records the event. It raises the interrupt, so software runs before the new mode is entered. Once software acknowledges, the block gives the go-ahead for exactly one cycle. A step whose enable bit is clear gets its go-ahead in the same cycle it is asked for. A level input selects delivery as a system management interrupt (SMI) or a non-maskable interrupt (NMI). An NMI is also gated by an external mask bit in the style of the AT real-time-clock index register. Recorded events stay in a status field until software clears them by writing ones.

Top module: `pwr_evt_irq`

## Requirements
- R1: After a synchronous reset the enable field and the status field read 0, and neither nmi_o nor smi_o is asserted.
- R2: A cycle with cfg_wr_i high loads cfg_data_i into the enable field, which is visible on enable_o from the next cycle. Bit positions: 0 suspend/resume pin, 1 low-speed PLL to Doze, 2 Doze to Sleep, 3 Sleep to Suspend, 4 Suspend to Off, 5/6/7 battery-low warnings 1/2/3 (batt_low_i[0]/[1]/[2]).
- R3: A step request (trans_step_i 0..3 selects the step at enable bit trans_step_i+1) whose enable bit is 0 gets trans_ready_o high in the same cycle, and no status bit is set.
- R4: A step request whose enable bit is 1 keeps trans_ready_o low, and the matching status bit is set at the next edge. The interrupt is raised while ready is still low.
- R5: After an enabled request has been captured, trans_ready_o stays low until irq_ack_i is seen. It then goes high for exactly the one cycle after the acknowledge.
- R6: A battery-low input is synchronized through two flip-flops and edge detected. A rising edge sets its status bit when enabled, and holding the level high makes no further event.
- R7: A rising edge on susres_i sets status bit 0 when enable bit 0 is set.
- R8: Events whose enable bit is 0 set no status bit.
- R9: Writing with clr_wr_i clears every status bit whose clr_data_i bit is 1. An event arriving in the same cycle wins over the clear.
- R10: With route_smi_i high, smi_o equals "any status bit set", whatever nmi_mask_i is, and nmi_o is low.
- R11: With route_smi_i low, nmi_o is high only while a status bit is set and nmi_mask_i is 0. A masked event stays pending and is delivered once the mask clears.
- R12: nmi_o and smi_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Enable field write strobe |
| cfg_data_i | input | 8 | Enable field write data |
| clr_wr_i | input | 1 | Status clear strobe |
| clr_data_i | input | 8 | Status bits to clear (1 = clear) |
| route_smi_i | input | 1 | 1 = deliver as SMI, 0 = as NMI |
| nmi_mask_i | input | 1 | External NMI mask, 1 blocks NMI |
| batt_low_i | input | 3 | Battery-low warnings 1..3 (asynchronous) |
| susres_i | input | 1 | Suspend/resume pin (asynchronous) |
| trans_req_i | input | 1 | Sequencer step request, held until ready |
| trans_step_i | input | 2 | Requested step, 0 = LS-PLL to Doze .. 3 = Suspend to Off |
| irq_ack_i | input | 1 | Software acknowledge releasing a held step |
| trans_ready_o | output | 1 | Go-ahead for the requested step |
| enable_o | output | 8 | Enable field readback |
| status_o | output | 8 | Pending event field |
| nmi_o | output | 1 | Non-maskable interrupt request |
| smi_o | output | 1 | System management interrupt request |

## Verification
The hardest case to reach is an event colliding with a clear. A step capture and a write-one-to-clear of the same bit must land on one clock edge, so the stimulus issues the request and an all-ones clear in the same cycle. A related case is an NMI that becomes pending while the mask is set and must be delivered only when the mask drops. This needs the synchronizer latency counted out before the mask is released. A long randomized phase follows a requester that obeys the hold protocol. It mixes acknowledges, enable rewrites and clears while transitions are in flight, and a behavioural model is compared on every cycle.

// File: rtl/pwr_evt_pkg.sv
package pwr_evt_pkg;

    localparam int NUM_STEPS  = 4;
    localparam int NUM_BATT   = 3;
    localparam int NUM_EDGE   = NUM_BATT + 1;
    localparam int REG_W      = 1 + NUM_STEPS + NUM_BATT;
    localparam int STEP_W     = $clog2(NUM_STEPS);
    localparam int BIT_SUSRES = 0;
    localparam int BIT_STEP0  = 1;
    localparam int BIT_BATT0  = BIT_STEP0 + NUM_STEPS;

    typedef logic [REG_W-1:0] evt_vec_t;

    typedef enum logic [STEP_W-1:0] {
        STEP_LSPLL_DOZE = 2'd0,
        STEP_DOZE_SLEEP = 2'd1,
        STEP_SLEEP_SUSP = 2'd2,
        STEP_SUSP_OFF   = 2'd3
    } step_e;

    typedef enum logic [1:0] {
        HOLD_IDLE,
        HOLD_WAIT,
        HOLD_GRANT
    } hold_e;

    typedef struct packed {
        logic  valid;
        step_e step;
    } trans_req_t;

    // One-hot status/enable position of a ladder step.
    function automatic evt_vec_t step_mask(step_e s);
        evt_vec_t m;
        m = '0;
        m[BIT_STEP0 + int'(s)] = 1'b1;
        return m;
    endfunction

    // Place edge events: index 0 is the suspend/resume pin, 1.. are battery warnings.
    function automatic evt_vec_t edge_to_vec(logic [NUM_EDGE-1:0] e);
        evt_vec_t m;
        m = '0;
        m[BIT_SUSRES] = e[0];
        for (int i = 0; i < NUM_BATT; i++) begin
            m[BIT_BATT0 + i] = e[i + 1];
        end
        return m;
    endfunction

endpackage

// File: rtl/pwr_evt_edge_det.sv
module pwr_evt_edge_det #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] rise
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        logic              prev;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
                prev  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], din[g]};
                prev  <= chain[STAGES-1];
            end
        end

        assign rise[g] = chain[STAGES-1] & ~prev;
    end

endmodule

// File: rtl/pwr_evt_trans_hold.sv
module pwr_evt_trans_hold
    import pwr_evt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  trans_req_t           req_i,
    input  logic [NUM_STEPS-1:0] en_step_i,
    input  logic                 ack_i,
    output logic                 ready_o,
    output evt_vec_t             set_o
);

    hold_e state_q, state_d;
    logic  step_hit;

    assign step_hit = req_i.valid && en_step_i[req_i.step];

    always_comb begin
        state_d = state_q;
        set_o   = '0;
        ready_o = 1'b0;
        case (state_q)
            HOLD_IDLE: begin
                if (req_i.valid) begin
                    if (step_hit) begin
                        set_o   = step_mask(req_i.step);
                        state_d = HOLD_WAIT;
                    end else begin
                        ready_o = 1'b1;
                    end
                end
            end
            HOLD_WAIT: begin
                if (ack_i) begin
                    state_d = HOLD_GRANT;
                end
            end
            HOLD_GRANT: begin
                ready_o = 1'b1;
                state_d = HOLD_IDLE;
            end
            default: state_d = HOLD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HOLD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/pwr_evt_regs.sv
module pwr_evt_regs
    import pwr_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cfg_wr_i,
    input  evt_vec_t cfg_data_i,
    input  logic     clr_wr_i,
    input  evt_vec_t clr_data_i,
    input  evt_vec_t set_i,
    output evt_vec_t en_o,
    output evt_vec_t sts_o
);

    evt_vec_t clr_mask;

    assign clr_mask = clr_wr_i ? clr_data_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_o  <= '0;
            sts_o <= '0;
        end else begin
            if (cfg_wr_i) begin
                en_o <= cfg_data_i;
            end
            // new events take precedence over a simultaneous clear
            sts_o <= (sts_o & ~clr_mask) | set_i;
        end
    end

endmodule

// File: rtl/pwr_evt_irq.sv
module pwr_evt_irq
    import pwr_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr_i,
    input  logic [REG_W-1:0]    cfg_data_i,
    input  logic                clr_wr_i,
    input  logic [REG_W-1:0]    clr_data_i,
    input  logic                route_smi_i,
    input  logic                nmi_mask_i,
    input  logic [NUM_BATT-1:0] batt_low_i,
    input  logic                susres_i,
    input  logic                trans_req_i,
    input  logic [STEP_W-1:0]   trans_step_i,
    input  logic                irq_ack_i,
    output logic                trans_ready_o,
    output logic [REG_W-1:0]    enable_o,
    output logic [REG_W-1:0]    status_o,
    output logic                nmi_o,
    output logic                smi_o
);

    logic [NUM_EDGE-1:0] edge_in;
    logic [NUM_EDGE-1:0] edge_rise;
    evt_vec_t            en_q;
    evt_vec_t            sts_q;
    evt_vec_t            edge_set;
    evt_vec_t            trans_set;
    trans_req_t          req;
    logic                pending;

    assign edge_in = {batt_low_i, susres_i};

    pwr_evt_edge_det #(
        .WIDTH  (NUM_EDGE),
        .STAGES (SYNC_STAGES)
    ) edge_i (
        .clk  (clk),
        .rst  (rst),
        .din  (edge_in),
        .rise (edge_rise)
    );

    assign edge_set  = edge_to_vec(edge_rise) & en_q;
    assign req.valid = trans_req_i;
    assign req.step  = step_e'(trans_step_i);

    pwr_evt_trans_hold hold_i (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req),
        .en_step_i (en_q[BIT_STEP0 +: NUM_STEPS]),
        .ack_i     (irq_ack_i),
        .ready_o   (trans_ready_o),
        .set_o     (trans_set)
    );

    pwr_evt_regs regs_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr_i   (cfg_wr_i),
        .cfg_data_i (cfg_data_i),
        .clr_wr_i   (clr_wr_i),
        .clr_data_i (clr_data_i),
        .set_i      (edge_set | trans_set),
        .en_o       (en_q),
        .sts_o      (sts_q)
    );

    assign pending  = |sts_q;
    assign enable_o = en_q;
    assign status_o = sts_q;
    assign smi_o    = pending & route_smi_i;
    assign nmi_o    = pending & ~route_smi_i & ~nmi_mask_i;

endmodule

// File: rtl/pwr_evt_irq_chk.sv
module pwr_evt_irq_chk
    import pwr_evt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_wr_i,
    input logic [REG_W-1:0] cfg_data_i,
    input logic             route_smi_i,
    input logic             nmi_mask_i,
    input logic             trans_req_i,
    input logic             irq_ack_i,
    input logic             trans_ready_o,
    input logic [REG_W-1:0] enable_o,
    input logic [REG_W-1:0] status_o,
    input logic             nmi_o,
    input logic             smi_o
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (enable_o == '0 && status_o == '0 && !nmi_o && !smi_o));

    assert_cfg_load_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_i |=> enable_o == $past(cfg_data_i));

    assert_capture_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (trans_req_i && !trans_ready_o && !$past(trans_req_i)) |=> status_o != '0);

    assert_hold_low_R5: assert property (@(posedge clk) disable iff (rst)
        (trans_req_i && !trans_ready_o && !irq_ack_i) |=> !trans_ready_o);

    assert_grant_after_ack_R5: assert property (@(posedge clk) disable iff (rst)
        (trans_req_i && !trans_ready_o && irq_ack_i
         && $past(trans_req_i && !trans_ready_o)) |=> trans_ready_o);

    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (enable_o == '0 && status_o == '0) |=> status_o == '0);

    assert_smi_route_R10: assert property (@(posedge clk) disable iff (rst)
        smi_o |-> (route_smi_i && status_o != '0));

    assert_nmi_mask_R11: assert property (@(posedge clk) disable iff (rst)
        nmi_mask_i |-> !nmi_o);

    assert_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        !(nmi_o && smi_o));

endmodule

bind pwr_evt_irq pwr_evt_irq_chk chk_i (.*);

// File: tb/pwr_evt_irq_tb.sv
`timescale 1ns/1ps
module pwr_evt_irq_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_data = 8'h00;
    logic       clr_wr = 1'b0;
    logic [7:0] clr_data = 8'h00;
    logic       route_smi = 1'b0;
    logic       nmi_mask = 1'b0;
    logic [2:0] batt = 3'b000;
    logic       susres = 1'b0;
    logic       req = 1'b0;
    logic [1:0] step = 2'd0;
    logic       ack = 1'b0;
    logic       ready;
    logic [7:0] en_rd;
    logic [7:0] sts_rd;
    logic       nmi;
    logic       smi;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    pwr_evt_irq dut_i (
        .clk           (clk),
        .rst           (rst),
        .cfg_wr_i      (cfg_wr),
        .cfg_data_i    (cfg_data),
        .clr_wr_i      (clr_wr),
        .clr_data_i    (clr_data),
        .route_smi_i   (route_smi),
        .nmi_mask_i    (nmi_mask),
        .batt_low_i    (batt),
        .susres_i      (susres),
        .trans_req_i   (req),
        .trans_step_i  (step),
        .irq_ack_i     (ack),
        .trans_ready_o (ready),
        .enable_o      (en_rd),
        .status_o      (sts_rd),
        .nmi_o         (nmi),
        .smi_o         (smi)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_en, m_sts;
    int         m_state;          // 0 free, 1 holding, 2 granting
    logic [3:0] hist[$];          // hist[0] = inputs seen at the latest edge

    always @(posedge clk) begin : model
        logic [3:0] ev;
        logic [7:0] setv;
        int         nst;
        if (rst) begin
            m_en    <= 8'h00;
            m_sts   <= 8'h00;
            m_state <= 0;
            hist = '{4'h0, 4'h0, 4'h0};
        end else begin
            ev   = hist[1] & ~hist[2];
            setv = {ev[3:1], 4'b0000, ev[0]} & m_en;
            nst  = m_state;
            if (m_state == 0 && req && m_en[int'(step) + 1]) begin
                setv[int'(step) + 1] = 1'b1;
                nst = 1;
            end else if (m_state == 1 && ack) begin
                nst = 2;
            end else if (m_state == 2) begin
                nst = 0;
            end
            m_sts   <= (m_sts & ~(clr_wr ? clr_data : 8'h00)) | setv;
            m_state <= nst;
            if (cfg_wr) m_en <= cfg_data;
            hist.push_front({batt, susres});
            void'(hist.pop_back());
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin : compare
        logic e_ready, e_nmi, e_smi;
        if (!rst && !done) begin
            e_ready = (m_state == 0 && req && !m_en[int'(step) + 1]) || m_state == 2;
            e_smi   = route_smi && (m_sts != 0);
            e_nmi   = !route_smi && !nmi_mask && (m_sts != 0);
            check(en_rd == m_en, "R2 enable", int'(en_rd), int'(m_en));
            check(sts_rd == m_sts, "R9 status", int'(sts_rd), int'(m_sts));
            check(ready == e_ready, "R5 ready", int'(ready), int'(e_ready));
            check(nmi == e_nmi, "R11 nmi", int'(nmi), int'(e_nmi));
            check(smi == e_smi, "R10 smi", int'(smi), int'(e_smi));
            check(!(nmi && smi), "R12 exclusive", int'({nmi, smi}), 0);
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic obs();
        @(negedge clk);
    endtask

    task automatic write_en(input logic [7:0] v);
        tick(); cfg_wr = 1'b1; cfg_data = v;
        tick(); cfg_wr = 1'b0;
    endtask

    task automatic clear_sts(input logic [7:0] v);
        tick(); clr_wr = 1'b1; clr_data = v;
        tick(); clr_wr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            vectors++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) tick();
        rst = 1'b0;
        obs();
        check(sts_rd == 8'h00 && en_rd == 8'h00, "R1 reset fields", int'({en_rd, sts_rd}), 0);
        check(!nmi && !smi, "R1 reset irq", int'({nmi, smi}), 0);

        // disabled step passes straight through
        tick(); req = 1'b1; step = 2'd1;
        obs();
        check(ready == 1'b1, "R3 same-cycle ready", int'(ready), 1);
        tick(); req = 1'b0;
        obs();
        check(sts_rd == 8'h00, "R3 no status", int'(sts_rd), 0);

        write_en(8'h1E);
        obs();
        check(en_rd == 8'h1E, "R2 readback", int'(en_rd), 'h1E);

        // enabled Sleep->Suspend step is held
        tick(); req = 1'b1; step = 2'd2;
        obs();
        check(ready == 1'b0, "R4 ready held", int'(ready), 0);
        tick();
        obs();
        check(sts_rd == 8'h08, "R4 status bit 3", int'(sts_rd), 'h08);
        check(nmi == 1'b1 && ready == 1'b0, "R4 irq before ready", int'({nmi, ready}), 2);
        repeat (3) tick();
        obs();
        check(ready == 1'b0, "R5 held without ack", int'(ready), 0);
        tick(); ack = 1'b1;
        obs();
        check(ready == 1'b0, "R5 not yet", int'(ready), 0);
        tick(); ack = 1'b0;
        obs();
        check(ready == 1'b1, "R5 grant pulse", int'(ready), 1);
        tick(); req = 1'b0;
        obs();
        check(ready == 1'b0, "R5 single cycle", int'(ready), 0);

        clear_sts(8'h08);
        obs();
        check(sts_rd == 8'h00 && !nmi, "R9 write-one clear", int'(sts_rd), 0);

        // capture and clear in the same cycle: event wins
        tick(); req = 1'b1; step = 2'd3; clr_wr = 1'b1; clr_data = 8'hFF;
        tick(); clr_wr = 1'b0;
        obs();
        check(sts_rd == 8'h10, "R9 set beats clear", int'(sts_rd), 'h10);
        tick(); ack = 1'b1;
        tick(); ack = 1'b0;
        tick(); req = 1'b0;
        clear_sts(8'hFF);

        // battery warning 2, held level
        write_en(8'hE1);
        tick(); batt = 3'b010;
        repeat (4) tick();
        obs();
        check(sts_rd == 8'h40, "R6 warning2 bit 6", int'(sts_rd), 'h40);
        clear_sts(8'h40);
        repeat (5) tick();
        obs();
        check(sts_rd == 8'h00, "R6 level no repeat", int'(sts_rd), 0);
        tick(); batt = 3'b000;

        // suspend/resume pulse routed as SMI with the mask set
        route_smi = 1'b1; nmi_mask = 1'b1;
        tick(); susres = 1'b1;
        tick(); susres = 1'b0;
        repeat (3) tick();
        obs();
        check(sts_rd == 8'h01, "R7 susres bit 0", int'(sts_rd), 'h01);
        check(smi == 1'b1 && nmi == 1'b0, "R10 smi ignores mask", int'({smi, nmi}), 2);
        clear_sts(8'h01);

        // NMI held behind the mask
        tick(); route_smi = 1'b0; nmi_mask = 1'b1; batt = 3'b100;
        repeat (4) tick();
        obs();
        check(sts_rd == 8'h80 && nmi == 1'b0, "R11 masked pending", int'({sts_rd, nmi}), 'h100);
        tick(); nmi_mask = 1'b0;
        obs();
        check(nmi == 1'b1, "R11 delivered on unmask", int'(nmi), 1);
        clear_sts(8'hFF);
        tick(); batt = 3'b000;

        // everything disabled
        write_en(8'h00);
        tick(); batt = 3'b111; susres = 1'b1;
        repeat (5) tick();
        obs();
        check(sts_rd == 8'h00, "R8 disabled events", int'(sts_rd), 0);
        tick(); batt = 3'b000; susres = 1'b0;
        repeat (4) tick();

        // randomized phase with a protocol-following requester
        begin
            bit last_ready;
            last_ready = 1'b0;
            for (int n = 0; n < 3000; n++) begin
                tick();
                if (req && last_ready) begin
                    req = 1'b0;
                end else if (!req && ($urandom_range(3) == 0)) begin
                    req  = 1'b1;
                    step = 2'($urandom_range(3));
                end
                ack       = ($urandom_range(3) == 0);
                cfg_wr    = ($urandom_range(15) == 0);
                cfg_data  = 8'($urandom);
                clr_wr    = ($urandom_range(5) == 0);
                clr_data  = 8'($urandom);
                route_smi = ($urandom_range(7) == 0) ? ~route_smi : route_smi;
                nmi_mask  = ($urandom_range(5) == 0) ? ~nmi_mask : nmi_mask;
                if ($urandom_range(3) == 0) batt = 3'($urandom);
                if ($urandom_range(3) == 0) susres = 1'($urandom);
                obs();
                last_ready = ready;
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule